// File: doc/BRIEF.md
# Calendar Time Registers with Deferred Commit

This block keeps wall-clock time as seconds, minutes and hours, and the calendar as day, month and a year offset. A one-cycle `tick` input advances the count once per second. Software sees three words through a small register port: a control/status word, a packed time word and a packed date word. The live time and date words can be read at any moment.

A write to the time or date word does not change the running count at once. The value goes into a shadow register and a busy bit in the control word is set. At the next `tick` the shadow value replaces the live word and the busy bit drops. On that tick the word takes the written value exactly and is not advanced. Software polls the busy bits before it writes again. A write that arrives while its busy bit is still set is dropped.

Day and month roll over using the real month lengths. February has 29 or 28 days according to a leap flag that software stores in the date word. The block never works out the leap flag itself. The year offset covers 64 years, counting from 1970 as 0.

Top module: `cal_regs`

## Requirements
- R1: After reset the time word reads 0, the date word reads day 1, month 1, year offset 0, leap flag 0 (0x0000_0101), and the control word reads 0.
- R2: Time word packing: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16. All other bits read 0.
- R3: Date word packing: day in bits 4:0, month (1 to 12) in bits 11:8, year offset in bits 21:16, leap flag in bit 22. All other bits read 0.
- R4: A write to the time word (address 1) sets control bit 8 from the next cycle. The live time word is unchanged until the next `tick`. On that tick the live word takes the written value with no increment, and bit 8 clears.
- R5: A write to the date word (address 2) sets control bit 7. The live date word is unchanged until the next `tick`. On that tick the live word takes the written value with no increment, and bit 7 clears.
- R6: A write to the time or date word while that word's busy bit is set is ignored. The value committed is the first one written.
- R7: Each tick advances seconds. Seconds wrap 59 to 0 and carry into minutes, minutes wrap 59 to 0 and carry into hours, and hours wrap 23 to 0 and carry one day into the date.
- R8: The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R9: In month 2 the day wraps after 29 when the stored leap flag is 1, and after 28 when it is 0. The leap flag is never changed by counting.
- R10: After December 31 the date becomes January 1 with the year offset plus one. Year offset 63 wraps to 0.
- R11: Without a tick, the time and date words hold. Writes to the control word (address 0) or to address 3 change nothing.
- R12: On a tick that commits a pending time write, no day carry is produced, even if the old time was 23:59:59.
- Control word: bit 9 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance/commit strobe, one cycle wide |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word select: 0 control, 1 time, 2 date |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word selected by reg_addr, from live state |

## Verification
The hardest situations to reach are tick edges that happen together: a pending time commit on the same tick where the old time would have carried into the date, and a date commit on the tick that also advances the time. Each of these is reached only by first committing a near-midnight time, then writing again before the next tick. The bench builds these states with directed write-then-tick sequences at February and year-end boundaries, under both leap-flag values. It then mixes random writes, ticks and idle cycles. Some random writes deliberately land while a busy bit is set, to exercise the dropped-write rule.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SEC_LAST   = 59;
    localparam int unsigned MIN_LAST   = 59;
    localparam int unsigned HOUR_LAST  = 23;
    localparam int unsigned MONTH_LAST = 12;

    localparam int unsigned SEL_CTRL = 0;
    localparam int unsigned SEL_TIME = 1;
    localparam int unsigned SEL_DATE = 2;

    localparam int unsigned BIT_DATE_BUSY = 7;
    localparam int unsigned BIT_TIME_BUSY = 8;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } clock_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] year;
        logic [3:0] month;
        logic [4:0] day;
    } cal_t;

    function automatic logic [WORD_W-1:0] pack_clock(input clock_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[5:0]   = c.sec;
        w[13:8]  = c.min;
        w[20:16] = c.hour;
        return w;
    endfunction

    function automatic clock_t unpack_clock(input logic [WORD_W-1:0] w);
        clock_t c;
        c.sec  = w[5:0];
        c.min  = w[13:8];
        c.hour = w[20:16];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cal(input cal_t d);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[4:0]   = d.day;
        w[11:8]  = d.month;
        w[21:16] = d.year;
        w[22]    = d.leap;
        return w;
    endfunction

    function automatic cal_t unpack_cal(input logic [WORD_W-1:0] w);
        cal_t d;
        d.day   = w[4:0];
        d.month = w[11:8];
        d.year  = w[21:16];
        d.leap  = w[22];
        return d;
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        logic [4:0] n;
        case (m)
            4'd2:                    n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cal_clock_unit.sv
module cal_clock_unit
    import cal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   wr,
    input  clock_t wval,
    output clock_t cur,
    output logic   busy,
    output logic   day_carry
);
    clock_t shadow;
    clock_t nxt;
    logic   wrap;

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (cur.sec >= 6'(SEC_LAST)) begin
            nxt.sec = '0;
            if (cur.min >= 6'(MIN_LAST)) begin
                nxt.min = '0;
                if (cur.hour >= 5'(HOUR_LAST)) begin
                    nxt.hour = '0;
                    wrap     = 1'b1;
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end

    assign day_carry = tick && !busy && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            shadow <= '0;
            busy   <= 1'b0;
        end else begin
            if (tick) begin
                if (busy) begin
                    cur  <= shadow;
                    busy <= 1'b0;
                end else begin
                    cur <= nxt;
                end
            end
            if (wr && !busy) begin
                shadow <= wval;
                busy   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic carry,
    input  logic wr,
    input  cal_t wval,
    output cal_t cur,
    output logic busy
);
    cal_t       shadow;
    cal_t       nxt;
    logic [4:0] last_day;

    always_comb begin
        last_day = month_len(cur.month, cur.leap);
        nxt      = cur;
        if (cur.day >= last_day) begin
            nxt.day = 5'd1;
            if (cur.month >= 4'(MONTH_LAST)) begin
                nxt.month = 4'd1;
                nxt.year  = cur.year + 6'd1;
            end else begin
                nxt.month = cur.month + 4'd1;
            end
        end else begin
            nxt.day = cur.day + 5'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '{leap: 1'b0, year: 6'd0, month: 4'd1, day: 5'd1};
            shadow <= '0;
            busy   <= 1'b0;
        end else begin
            if (tick) begin
                if (busy) begin
                    cur  <= shadow;
                    busy <= 1'b0;
                end else if (carry) begin
                    cur <= nxt;
                end
            end
            if (wr && !busy) begin
                shadow <= wval;
                busy   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cal_port.sv
module cal_port
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  clock_t            clk_cur,
    input  cal_t              cal_cur,
    input  logic              clk_busy,
    input  logic              cal_busy,
    output logic              wr_clock,
    output logic              wr_cal,
    output clock_t            clk_wval,
    output cal_t              cal_wval,
    output logic [WORD_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SEL_CTRL);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(SEL_TIME);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(SEL_DATE);

    assign wr_clock = reg_wr && (reg_addr == A_TIME);
    assign wr_cal   = reg_wr && (reg_addr == A_DATE);
    assign clk_wval = unpack_clock(reg_wdata);
    assign cal_wval = unpack_cal(reg_wdata);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[BIT_TIME_BUSY] = clk_busy;
            reg_rdata[BIT_DATE_BUSY] = cal_busy;
        end else if (reg_addr == A_TIME) begin
            reg_rdata = pack_clock(clk_cur);
        end else if (reg_addr == A_DATE) begin
            reg_rdata = pack_cal(cal_cur);
        end
    end
endmodule

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    clock_t time_q;
    cal_t   date_q;
    clock_t time_wv;
    cal_t   date_wv;
    logic   time_busy;
    logic   date_busy;
    logic   wr_time;
    logic   wr_date;
    logic   carry;

    cal_port #(.ADDR_W(ADDR_W)) u_port (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .clk_cur   (time_q),
        .cal_cur   (date_q),
        .clk_busy  (time_busy),
        .cal_busy  (date_busy),
        .wr_clock  (wr_time),
        .wr_cal    (wr_date),
        .clk_wval  (time_wv),
        .cal_wval  (date_wv),
        .reg_rdata (reg_rdata)
    );

    cal_clock_unit u_clock (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr        (wr_time),
        .wval      (time_wv),
        .cur       (time_q),
        .busy      (time_busy),
        .day_carry (carry)
    );

    cal_date_unit u_date (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .carry (carry),
        .wr    (wr_date),
        .wval  (date_wv),
        .cur   (date_q),
        .busy  (date_busy)
    );
endmodule

// File: rtl/cal_regs_chk.sv
module cal_regs_chk
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              time_busy,
    input logic              date_busy,
    input clock_t            time_q,
    input cal_t              date_q
);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(SEL_TIME);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(SEL_DATE);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (time_q == '0 && date_q.day == 5'd1 && date_q.month == 4'd1
                        && date_q.year == '0 && !date_q.leap && !time_busy && !date_busy));

    a_r4_time_busy_set: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_TIME && !time_busy) |=> time_busy);

    a_r4_time_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (time_busy && !tick) |=> time_busy);

    a_r4_time_busy_clear: assert property (@(posedge clk) disable iff (rst)
        (time_busy && tick) |=> !time_busy);

    a_r5_date_busy_set: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DATE && !date_busy) |=> date_busy);

    a_r5_date_busy_clear: assert property (@(posedge clk) disable iff (rst)
        (date_busy && tick) |=> !date_busy);

    a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(time_q) && $stable(date_q)));

    a_r9_leap_kept: assert property (@(posedge clk) disable iff (rst)
        (tick && !date_busy) |=> $stable(date_q.leap));

    a_r12_commit_no_carry: assert property (@(posedge clk) disable iff (rst)
        (tick && time_busy && !date_busy) |=> $stable(date_q));
endmodule

bind cal_regs cal_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .time_busy (time_busy),
    .date_busy (date_busy),
    .time_q    (time_q),
    .date_q    (date_q)
);

// File: tb/sim_cal_regs.sv
`timescale 1ns/1ps
module sim_cal_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    int m_s, m_m, m_h, m_d, m_mo, m_y, m_l;
    int p_s, p_m, p_h, p_d, p_mo, p_y, p_l;
    bit m_tb, m_db;

    always #5 clk = ~clk;

    cal_regs u0 (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int mdays(int mo, int lp);
        if (mo == 2) return (lp != 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tword(int h, int mi, int s);
        return (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] dword(int y, int mo, int d, int lp);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    task automatic model_tick();
        bit c;
        c = 1'b0;
        if (m_tb) begin
            m_s = p_s; m_m = p_m; m_h = p_h; m_tb = 1'b0;
        end else begin
            m_s++;
            if (m_s > 59) begin
                m_s = 0; m_m++;
                if (m_m > 59) begin
                    m_m = 0; m_h++;
                    if (m_h > 23) begin m_h = 0; c = 1'b1; end
                end
            end
        end
        if (m_db) begin
            m_d = p_d; m_mo = p_mo; m_y = p_y; m_l = p_l; m_db = 1'b0;
        end else if (c) begin
            m_d++;
            if (m_d > mdays(m_mo, m_l)) begin
                m_d = 1; m_mo++;
                if (m_mo > 12) begin m_mo = 1; m_y = (m_y + 1) % 64; end
            end
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        model_tick();
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
        if (a == 2'd1 && !m_tb) begin
            p_s = int'(v[5:0]); p_m = int'(v[13:8]); p_h = int'(v[20:16]); m_tb = 1'b1;
        end
        if (a == 2'd2 && !m_db) begin
            p_d = int'(v[4:0]); p_mo = int'(v[11:8]); p_y = int'(v[21:16]); p_l = int'(v[22]); m_db = 1'b1;
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(2'd0, v); cmp(tag, "ctrl", v, (32'(m_tb) << 8) | (32'(m_db) << 7));
        rd(2'd1, v); cmp(tag, "time", v, tword(m_h, m_m, m_s));
        rd(2'd2, v); cmp(tag, "date", v, dword(m_y, m_mo, m_d, m_l));
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        do_wr(2'd1, t); do_wr(2'd2, d); do_tick();
    endtask

    initial begin
        int sd;
        sd = $urandom(32'h5eed);
        m_s = 0; m_m = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_l = 0;
        p_s = 0; p_m = 0; p_h = 0; p_d = 0; p_mo = 0; p_y = 0; p_l = 0;
        m_tb = 0; m_db = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R4/R6: deferred time write, second write dropped
        do_wr(2'd1, tword(23, 59, 58));
        check_all("R4");
        do_wr(2'd1, tword(7, 7, 7));
        check_all("R6");
        do_tick();
        check_all("R4");
        check_all("R2");

        // R5: date commit while time advances
        do_wr(2'd2, dword(5, 1, 31, 0));
        check_all("R5");
        do_tick();
        check_all("R5");
        check_all("R3");

        // R7/R8: midnight carry Jan 31 -> Feb 1
        do_tick();
        check_all("R7");
        check_all("R8");

        // R9: Feb 28 no-leap -> Mar 1
        load(tword(23, 59, 59), dword(6, 2, 28, 0));
        do_tick();
        check_all("R9");
        // R9: Feb 28 leap -> Feb 29 -> Mar 1, leap kept
        load(tword(23, 59, 59), dword(2, 2, 28, 1));
        do_tick();
        check_all("R9");
        do_wr(2'd1, tword(23, 59, 59)); do_tick();
        do_tick();
        check_all("R9");

        // R8: Apr 30 -> May 1
        load(tword(23, 59, 59), dword(9, 4, 30, 0));
        do_tick();
        check_all("R8");

        // R10: year end and year wrap
        load(tword(23, 59, 59), dword(10, 12, 31, 0));
        do_tick();
        check_all("R10");
        load(tword(23, 59, 59), dword(63, 12, 31, 0));
        do_tick();
        check_all("R10");

        // R12: commit on a would-be carry tick
        load(tword(23, 59, 59), dword(20, 6, 15, 0));
        do_wr(2'd1, tword(12, 0, 0));
        do_tick();
        check_all("R12");

        // R7: minute and hour carry
        load(tword(10, 59, 59), dword(20, 6, 15, 0));
        do_tick();
        check_all("R7");

        // R11: stray writes and idle cycles
        do_wr(2'd0, 32'hFFFF_FFFF);
        do_wr(2'd3, 32'hFFFF_FFFF);
        repeat (5) @(negedge clk);
        check_all("R11");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 6) begin
                do_tick();
            end else if (op == 6) begin
                do_wr(2'd1, tword(int'($urandom_range(20, 23)), int'($urandom_range(55, 59)),
                                  int'($urandom_range(50, 59))));
            end else if (op == 7) begin
                int mo;
                mo = int'($urandom_range(1, 12));
                do_wr(2'd2, dword(int'($urandom_range(0, 63)), mo,
                                  mdays(mo, 0) - int'($urandom_range(0, 1)),
                                  int'($urandom_range(0, 1))));
            end else begin
                @(negedge clk);
            end
            check_all("R6");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule